// File: doc/BRIEF.md
# Serial Command and Telemetry Responder

This block sits between a spacecraft bus serial link and the payload's measurement logic. It listens on an asynchronous 8N1 receive line for single-byte commands. Two commands return telemetry: a science request sends back the seven 24-bit photon counts as one 168-bit packet, and a housekeeping request sends back the eleven 16-bit temperature words as one 176-bit packet. Two more commands switch the photometer channels off or on as a group through per-channel shutdown outputs.

Every packet goes out on the transmit line as a run of 8N1 bytes, most significant byte first. The packet contents are captured in the cycle the request is accepted, so the source registers may change freely while the bytes are shifted out. Accepting a science request also raises a one-cycle snapshot strobe. The photon counters use it to capture their totals and restart counting. Only one packet is handled at a time. A recognized command that arrives while a packet is still leaving is thrown away, and a sticky overrun flag records the loss.

Top module: `cmd_telemetry_responder`

## Requirements
- R1: After reset, the transmit line is high, every shutdown output is 1 (channels off), and the snapshot strobe and overrun flag are 0.
- R2: A received byte is accepted only if the line is still low half a bit period after the falling edge. A shorter low pulse yields no byte, and a frame whose stop bit is low is discarded.
- R3: Command byte 0x01 causes 21 bytes to be sent from `sci_data_i`, starting with bits [167:160]. Channel 0 occupies bits [167:144].
- R4: Command byte 0x02 causes 22 bytes to be sent from `hk_data_i`, starting with bits [175:168]. Word 0 occupies bits [175:160].
- R5: Packet contents are captured when the request is accepted. Later changes to the data inputs do not alter the packet being sent.
- R6: Command byte 0x03 sets all shutdown outputs to 1 in the cycle after it is decoded. Command byte 0x04 clears all of them to 0. The outputs are always either all 1 or all 0.
- R7: Any byte other than 0x01 to 0x04 is ignored. It causes no transmission, no strobe, no shutdown change and no overrun.
- R8: `snap_o` is high for exactly one cycle for each accepted 0x01 command, and never for any other byte.
- R9: A command from 0x01 to 0x04 that is decoded while a packet is pending or being sent is dropped and sets `overrun_o`. The flag then stays at 1 until reset.
- R10: Each transmitted byte is framed as a 0 start bit, eight data bits sent LSB first, and a 1 stop bit, each held `CLKS_PER_BIT` cycles. The line idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial command line from the bus, idle high |
| tx_o | output | 1 | Serial telemetry line to the bus, idle high |
| sci_data_i | input | 168 | Seven 24-bit photon counts, channel 0 in the top bits |
| hk_data_i | input | 176 | Eleven 16-bit temperature words, word 0 in the top bits |
| pmt_off_o | output | 7 | Per-channel shutdown, 1 = power switch off |
| snap_o | output | 1 | One-cycle strobe on an accepted science request |
| overrun_o | output | 1 | Sticky flag: a command was dropped while busy |

## Verification
The two functions that can coincide are command decoding on the receive side and packet shift-out on the transmit side. The bench provokes this by sending a housekeeping request and then, while its 22 reply bytes are still leaving, a power-off command. The result is judged in three ways: the reply must still match the words captured at acceptance byte for byte, the shutdown outputs must keep their prior value, and `overrun_o` must rise and stay high through later commands. The snapshot strobe is counted across the whole run and must match the number of accepted science requests, even when data inputs change in mid-packet.

// File: rtl/cmd_tlm_pkg.sv
// Shared command codes and receiver states for the command/telemetry responder.
package cmd_tlm_pkg;

    typedef enum logic [7:0] {
        CMD_SCI = 8'h01,
        CMD_HK  = 8'h02,
        CMD_OFF = 8'h03,
        CMD_ON  = 8'h04
    } cmd_code_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/cmd_uart_rx.sv
// 8N1 receiver. Samples each bit at its middle after confirming the start bit
// at half a bit period. Assumes rx_i is asynchronous, so it is synchronized
// first. Frames with a low stop bit are discarded. Byte output is valid for
// one cycle.
module cmd_uart_rx
    import cmd_tlm_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    output logic       byte_valid_o,
    output logic [7:0] byte_o
);
    localparam int CW   = $clog2(CLKS_PER_BIT + 1);
    localparam int HALF = CLKS_PER_BIT / 2;

    logic [1:0]    sync_q;
    logic          rx_s;
    rx_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    data_q;
    logic          valid_q;

    assign rx_s = sync_q[1];

    // Two-stage synchronizer for the incoming line
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end

    // Frame state machine: start check, data sampling, stop check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    if (!rx_s) state_q <= RX_START;
                end
                RX_START: begin
                    if (cnt_q == CW'(HALF - 1)) begin
                        cnt_q   <= '0;
                        bit_q   <= '0;
                        state_q <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
                        cnt_q  <= '0;
                        data_q <= {rx_s, data_q[7:1]};
                        bit_q  <= bit_q + 1'b1;
                        if (bit_q == 3'd7) state_q <= RX_STOP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
                        cnt_q   <= '0;
                        valid_q <= rx_s;
                        state_q <= RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign byte_valid_o = valid_q;
    assign byte_o       = data_q;
endmodule

// File: rtl/tlm_uart_tx.sv
// 8N1 transmitter. Loads a byte on start_i while idle and shifts out
// start, eight data bits LSB first, and stop. Assumes start_i is only
// raised while busy_o is low.
module tlm_uart_tx #(
    parameter int CLKS_PER_BIT = 434
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] data_i,
    output logic       busy_o,
    output logic       tx_o
);
    localparam int CW = $clog2(CLKS_PER_BIT + 1);

    logic [9:0]    shreg_q;
    logic [3:0]    left_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // Frame shifter; idle shift register is all ones so the line rests high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '1;
            left_q  <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
        end else if (!busy_q) begin
            if (start_i) begin
                shreg_q <= {1'b1, data_i, 1'b0};
                left_q  <= 4'd10;
                cnt_q   <= '0;
                busy_q  <= 1'b1;
            end
        end else if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
            cnt_q   <= '0;
            shreg_q <= {1'b1, shreg_q[9:1]};
            left_q  <= left_q - 1'b1;
            if (left_q == 4'd1) busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign tx_o   = shreg_q[0];
endmodule

// File: rtl/tlm_packet_shifter.sv
// Captures a wide packet on a load pulse and feeds it byte by byte, most
// significant first, into the transmitter. Assumes a load pulse only arrives
// while active_o is low.
module tlm_packet_shifter #(
    parameter int SCI_W = 168,
    parameter int HK_W  = 176
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_sci_i,
    input  logic             load_hk_i,
    input  logic [SCI_W-1:0] sci_data_i,
    input  logic [HK_W-1:0]  hk_data_i,
    input  logic             tx_busy_i,
    output logic             tx_start_o,
    output logic [7:0]       tx_byte_o,
    output logic             active_o
);
    localparam int BUF_W     = (SCI_W > HK_W) ? SCI_W : HK_W;
    localparam int SCI_BYTES = SCI_W / 8;
    localparam int HK_BYTES  = HK_W / 8;
    localparam int LW        = $clog2(BUF_W / 8 + 1);

    logic [BUF_W-1:0] buf_q;
    logic [LW-1:0]    left_q;
    logic             start_q;
    logic [7:0]       byte_q;

    // Load the packet, then hand one byte to the transmitter whenever it is free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q   <= '0;
            left_q  <= '0;
            start_q <= 1'b0;
            byte_q  <= '0;
        end else if (load_sci_i) begin
            buf_q   <= BUF_W'(sci_data_i) << (BUF_W - SCI_W);
            left_q  <= LW'(SCI_BYTES);
            start_q <= 1'b0;
        end else if (load_hk_i) begin
            buf_q   <= BUF_W'(hk_data_i) << (BUF_W - HK_W);
            left_q  <= LW'(HK_BYTES);
            start_q <= 1'b0;
        end else if (left_q != '0 && !tx_busy_i && !start_q) begin
            start_q <= 1'b1;
            byte_q  <= buf_q[BUF_W-1 -: 8];
            buf_q   <= buf_q << 8;
            left_q  <= left_q - 1'b1;
        end else begin
            start_q <= 1'b0;
        end
    end

    assign tx_start_o = start_q;
    assign tx_byte_o  = byte_q;
    assign active_o   = (left_q != '0) || start_q || tx_busy_i;
endmodule

// File: rtl/cmd_telemetry_responder.sv
// Top level: receives command bytes, decodes the four commands, returns
// science or housekeeping packets, drives photometer shutdown lines, and
// strobes the counters on a science request. Assumes packet widths are whole
// bytes and that commands only take effect while no packet is in flight.
module cmd_telemetry_responder
    import cmd_tlm_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434,
    parameter int N_PMT        = 7,
    parameter int CNT_W        = 24,
    parameter int N_TEMP       = 11,
    parameter int TEMP_W       = 16,
    localparam int SCI_W       = N_PMT * CNT_W,
    localparam int HK_W        = N_TEMP * TEMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    output logic             tx_o,
    input  logic [SCI_W-1:0] sci_data_i,
    input  logic [HK_W-1:0]  hk_data_i,
    output logic [N_PMT-1:0] pmt_off_o,
    output logic             snap_o,
    output logic             overrun_o
);
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       tx_start;
    logic [7:0] tx_byte;
    logic       tx_busy;
    logic       pkt_active;
    logic       accept;
    logic       is_cmd;
    logic       load_sci;
    logic       load_hk;

    logic [N_PMT-1:0] pmt_off_q;
    logic             snap_q;
    logic             overrun_q;

    cmd_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_i         (rx_i),
        .byte_valid_o (rx_valid),
        .byte_o       (rx_byte)
    );

    // Command classification for the byte just received
    always_comb begin
        is_cmd   = (rx_byte == CMD_SCI) || (rx_byte == CMD_HK) ||
                   (rx_byte == CMD_OFF) || (rx_byte == CMD_ON);
        accept   = rx_valid && !pkt_active;
        load_sci = accept && (rx_byte == CMD_SCI);
        load_hk  = accept && (rx_byte == CMD_HK);
    end

    // Shutdown lines, snapshot strobe and sticky overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pmt_off_q <= '1;
            snap_q    <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            snap_q <= load_sci;
            if (accept && rx_byte == CMD_OFF) pmt_off_q <= '1;
            if (accept && rx_byte == CMD_ON)  pmt_off_q <= '0;
            if (rx_valid && is_cmd && pkt_active) overrun_q <= 1'b1;
        end
    end

    tlm_packet_shifter #(.SCI_W(SCI_W), .HK_W(HK_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_sci_i (load_sci),
        .load_hk_i  (load_hk),
        .sci_data_i (sci_data_i),
        .hk_data_i  (hk_data_i),
        .tx_busy_i  (tx_busy),
        .tx_start_o (tx_start),
        .tx_byte_o  (tx_byte),
        .active_o   (pkt_active)
    );

    tlm_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_start),
        .data_i  (tx_byte),
        .busy_o  (tx_busy),
        .tx_o    (tx_o)
    );

    assign pmt_off_o = pmt_off_q;
    assign snap_o    = snap_q;
    assign overrun_o = overrun_q;
endmodule

// File: rtl/cmd_telemetry_checker.sv
// Property checker for the responder, attached by bind. Observes the decoded
// receive byte, the packet-active state and the transmitter busy flag.
module cmd_telemetry_checker #(
    parameter int N_PMT = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic [7:0]       rx_byte,
    input logic             pkt_active,
    input logic             tx_busy,
    input logic             tx_o,
    input logic [N_PMT-1:0] pmt_off_o,
    input logic             snap_o,
    input logic             overrun_o
);
    assert_snap_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snap_o |=> !snap_o);

    assert_snap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snap_o |-> $past(rx_valid && rx_byte == 8'h01 && !pkt_active));

    assert_off_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_byte == 8'h03 && !pkt_active) |=> (pmt_off_o == '1));

    assert_on_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_byte == 8'h04 && !pkt_active) |=> (pmt_off_o == '0));

    assert_pmt_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pmt_off_o) == 0) || ($countones(pmt_off_o) == N_PMT));

    assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_byte >= 8'h01 && rx_byte <= 8'h04 && pkt_active) |=> overrun_o);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    assert_line_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_o);
endmodule

bind cmd_telemetry_responder cmd_telemetry_checker #(.N_PMT(N_PMT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .pkt_active (pkt_active),
    .tx_busy    (tx_busy),
    .tx_o       (tx_o),
    .pmt_off_o  (pmt_off_o),
    .snap_o     (snap_o),
    .overrun_o  (overrun_o)
);

// File: tb/test_cmd_telemetry_responder.sv
module test_cmd_telemetry_responder;
    localparam int CPB = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_i = 1'b1;
    logic         tx_o;
    logic [167:0] sci_data_i = '0;
    logic [175:0] hk_data_i = '0;
    logic [6:0]   pmt_off_o;
    logic         snap_o;
    logic         overrun_o;

    int checks = 0;
    int fails = 0;
    int snaps = 0;
    logic [7:0] got[$];
    logic [7:0] expq[$];
    bit done = 0;

    always #10 clk = ~clk;

    cmd_telemetry_responder #(.CLKS_PER_BIT(CPB)) i_cmd_telemetry_responder (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_i       (rx_i),
        .tx_o       (tx_o),
        .sci_data_i (sci_data_i),
        .hk_data_i  (hk_data_i),
        .pmt_off_o  (pmt_off_o),
        .snap_o     (snap_o),
        .overrun_o  (overrun_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_test();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Strobe counter (R8)
    always @(negedge clk) if (rst_n && snap_o) snaps++;

    // Line monitor: decodes transmitted frames, checks start/stop framing (R10)
    initial begin
        logic [7:0] b;
        forever begin
            @(negedge clk);
            if (rst_n && !tx_o) begin
                repeat (CPB / 2) @(negedge clk);
                chk("R10 start bit", 32'(tx_o), 32'h0);
                for (int i = 0; i < 8; i++) begin
                    repeat (CPB) @(negedge clk);
                    b[i] = tx_o;
                end
                repeat (CPB) @(negedge clk);
                chk("R10 stop bit", 32'(tx_o), 32'h1);
                got.push_back(b);
            end
        end
    end

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        @(negedge clk);
        rx_i = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_i = b[i];
            repeat (CPB) @(negedge clk);
        end
        rx_i = good_stop;
        repeat (CPB) @(negedge clk);
        rx_i = 1'b1;
        repeat (2 * CPB) @(negedge clk);
    endtask

    task automatic wait_bytes(input int n);
        int t = 0;
        while (got.size() < n && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (2 * CPB) @(negedge clk);
    endtask

    task automatic compare_packet(input string req);
        chk({req, " byte count"}, 32'(got.size()), 32'(expq.size()));
        for (int i = 0; i < expq.size() && i < got.size(); i++)
            chk(req, 32'(got[i]), 32'(expq[i]));
        got.delete();
        expq.delete();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        logic [167:0] sci_ref;
        logic [175:0] hk_ref;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx idle", 32'(tx_o), 32'h1);
        chk("R1 shutdown", 32'(pmt_off_o), 32'h7F);
        chk("R1 snap", 32'(snap_o), 32'h0);
        chk("R1 overrun", 32'(overrun_o), 32'h0);

        // R2 short glitch is not a start bit
        rx_i = 1'b0;
        repeat (2) @(negedge clk);
        rx_i = 1'b1;
        repeat (24 * CPB) @(negedge clk);
        chk("R2 glitch no byte", 32'(got.size()), 32'h0);
        chk("R2 glitch shutdown", 32'(pmt_off_o), 32'h7F);

        // R2 bad stop bit discards an ON command
        send_byte(8'h04, 1'b0);
        chk("R2 bad stop discarded", 32'(pmt_off_o), 32'h7F);

        // R6 on / off / on
        send_byte(8'h04, 1'b1);
        chk("R6 on", 32'(pmt_off_o), 32'h00);
        send_byte(8'h03, 1'b1);
        chk("R6 off", 32'(pmt_off_o), 32'h7F);
        send_byte(8'h04, 1'b1);
        chk("R6 on again", 32'(pmt_off_o), 32'h00);

        // R7 unknown code ignored
        send_byte(8'h55, 1'b1);
        send_byte(8'h00, 1'b1);
        repeat (12 * CPB) @(negedge clk);
        chk("R7 no tx", 32'(got.size()), 32'h0);
        chk("R7 no strobe", 32'(snaps), 32'h0);
        chk("R7 shutdown kept", 32'(pmt_off_o), 32'h00);
        chk("R7 no overrun", 32'(overrun_o), 32'h0);

        // R3/R5/R8 science packet, input changed after acceptance
        for (int c = 0; c < 7; c++) sci_data_i[167 - 24*c -: 24] = 24'h1000A0 + 24'(c * 24'h010203);
        sci_ref = sci_data_i;
        for (int i = 0; i < 21; i++) expq.push_back(sci_ref[167 - 8*i -: 8]);
        send_byte(8'h01, 1'b1);
        sci_data_i = ~sci_data_i;
        chk("R8 one strobe", 32'(snaps), 32'h1);
        wait_bytes(21);
        compare_packet("R3 R5 science");

        // R4 housekeeping packet
        for (int w = 0; w < 11; w++) hk_data_i[175 - 16*w -: 16] = 16'hA500 + 16'(w * 16'h0111);
        hk_ref = hk_data_i;
        for (int i = 0; i < 22; i++) expq.push_back(hk_ref[175 - 8*i -: 8]);
        send_byte(8'h02, 1'b1);
        hk_data_i = '0;
        wait_bytes(22);
        compare_packet("R4 R5 housekeeping");
        chk("R8 no strobe on hk", 32'(snaps), 32'h1);
        chk("R9 no overrun yet", 32'(overrun_o), 32'h0);

        // R9 command during transmission is dropped
        hk_data_i = hk_ref;
        expq.delete();
        for (int i = 0; i < 22; i++) expq.push_back(hk_ref[175 - 8*i -: 8]);
        send_byte(8'h02, 1'b1);
        send_byte(8'h03, 1'b1);
        chk("R9 overrun set", 32'(overrun_o), 32'h1);
        chk("R9 off dropped", 32'(pmt_off_o), 32'h00);
        wait_bytes(22);
        compare_packet("R9 packet intact");

        // R9 sticky; command works again once idle
        send_byte(8'h03, 1'b1);
        chk("R6 off after idle", 32'(pmt_off_o), 32'h7F);
        chk("R9 overrun sticky", 32'(overrun_o), 32'h1);
        chk("R8 total strobes", 32'(snaps), 32'h1);

        finish_test();
    end
endmodule